// File: doc/BRIEF.md
# Alternating-Axis Differential Bit Encoder

This block converts a serial NRZ bit stream into the encoded bit sequence that drives a quadrature wavelet generator. Its output polarity matches a conventional differentially encoded GMSK transmitter. The encoder keeps a phase state with four positions: +X, +Y, -X and -Y. Each accepted bit moves the state a quarter turn, so the state sits on the X axis and the Y axis in turn. An internal flag toggles with every bit and names the axis that the state currently occupies. The encoded output tells whether the state lies on the positive half of that axis.

Upstream logic presents one data bit with a single-cycle strobe per bit period. At the nominal rate this is 270.833 kb/s, far below the clock rate. The encoded bit, the flag and a one-cycle valid pulse appear in the cycle after the strobe. Downstream wavelet selection uses the flag to decide which half of a symbol waveform it applies to which channel.

Top module: `alt_axis_encoder`

## Requirements
- R1: After reset the state is +X, flag_o is 0, the stored previous bit is 1, enc_o is 1 and valid_o is 0.
- R2: On each strobe the differential bit is bit_i XOR the previous accepted bit, and bit_i then becomes the previous bit.
- R3: A differential bit of 0 turns the state +90 degrees (+X to +Y to -X to -Y to +X). A differential bit of 1 turns it -90 degrees.
- R4: Every strobe moves the state to the other axis and toggles flag_o. flag_o=0 marks the X axis and flag_o=1 marks the Y axis.
- R5: enc_o is 1 when the state is on the positive half of the axis that flag_o selects (+X or +Y), and 0 otherwise.
- R6: valid_o is 1 for exactly the cycle after each strobe cycle and 0 otherwise.
- R7: Without a strobe, bit_i is ignored. The state, flag_o and enc_o keep their values.
- R8: Strobes on consecutive cycles are each accepted as a separate bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Serial NRZ data bit, sampled on strobe |
| strobe_i | input | 1 | One-cycle pulse per bit period |
| enc_o | output | 1 | Encoded output bit |
| flag_o | output | 1 | Alternating axis flag (0 = X, 1 = Y) |
| valid_o | output | 1 | High for the cycle after an accepted bit |

## Verification
The assertions check on every cycle that the quarter-turn direction follows the XOR of the new and previous bits. They also check that the state changes axis on each strobe, that the flag always agrees with the state's axis, that the state holds between strobes, and that the valid pulse tracks the strobe. Some behaviour is visible only at the ports across whole bit sequences: the reset values, the encoded polarity sequences for all-ones, alternating and pseudo-random data, the rejection of bit_i changes without a strobe, and back-to-back strobes. The bench scenarios cover these.

// File: rtl/alt_enc_pkg.sv
package alt_enc_pkg;
  typedef enum logic [1:0] {
    PH_POS_X = 2'd0,
    PH_POS_Y = 2'd1,
    PH_NEG_X = 2'd2,
    PH_NEG_Y = 2'd3
  } phase_e;

  localparam logic [1:0] STEP_CCW = 2'd1;
  localparam logic [1:0] STEP_CW  = 2'd3;
endpackage

// File: rtl/alt_enc_diff.sv
module alt_enc_diff #(
  parameter logic PREV_INIT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic strobe_i,
  output logic diff_o,
  output logic prev_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prev_q <= PREV_INIT;
    else if (strobe_i) prev_q <= bit_i;
  end

  assign diff_o = bit_i ^ prev_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/alt_enc_phase.sv
module alt_enc_phase
  import alt_enc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   strobe_i,
  input  logic   diff_i,
  output phase_e phase_o
);
  phase_e phase_q;
  logic [1:0] step;

  // diff 0 -> +90 deg, diff 1 -> -90 deg
  assign step = diff_i ? STEP_CW : STEP_CCW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= PH_POS_X;
    else if (strobe_i) phase_q <= phase_e'(phase_q + step);
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/alt_enc_out.sv
module alt_enc_out
  import alt_enc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   strobe_i,
  input  phase_e phase_i,
  output logic   flag_o,
  output logic   enc_o,
  output logic   valid_o
);
  logic flag_q;
  logic valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= strobe_i;
      if (strobe_i) flag_q <= ~flag_q;
    end
  end

  // flag picks the axis whose positive half is reported
  assign enc_o   = flag_q ? (phase_i == PH_POS_Y) : (phase_i == PH_POS_X);
  assign flag_o  = flag_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/alt_axis_encoder.sv
module alt_axis_encoder
  import alt_enc_pkg::*;
#(
  parameter logic PREV_INIT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic strobe_i,
  output logic enc_o,
  output logic flag_o,
  output logic valid_o
);
  logic   diff;
  logic   prev_q;
  phase_e phase_q;

  alt_enc_diff #(.PREV_INIT(PREV_INIT)) u_diff (
    .clk_i, .rst_ni, .bit_i, .strobe_i,
    .diff_o(diff), .prev_o(prev_q)
  );

  alt_enc_phase u_phase (
    .clk_i, .rst_ni, .strobe_i,
    .diff_i(diff), .phase_o(phase_q)
  );

  alt_enc_out u_out (
    .clk_i, .rst_ni, .strobe_i,
    .phase_i(phase_q), .flag_o, .enc_o, .valid_o
  );
endmodule

// File: rtl/alt_axis_encoder_chk.sv
module alt_axis_encoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_i,
  input logic       strobe_i,
  input logic       prev_q,
  input logic [1:0] phase_q,
  input logic       flag_o,
  input logic       valid_o
);
  // R2 R3
  a_r3_rotation_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> phase_q == 2'($past(phase_q) + (($past(bit_i) ^ $past(prev_q)) ? 2'd3 : 2'd1)));

  a_r2_prev_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> prev_q == $past(bit_i));

  a_r4_axis_alternates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> phase_q[0] != $past(phase_q[0]));

  a_r4_flag_axis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o == phase_q[0]);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(phase_q) && $stable(flag_o) && $stable(prev_q));

  a_r6_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> valid_o);

  a_r6_valid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !valid_o);
endmodule

bind alt_axis_encoder alt_axis_encoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .strobe_i(strobe_i),
  .prev_q(prev_q), .phase_q(phase_q), .flag_o(flag_o), .valid_o(valid_o)
);

// File: tb/sim_alt_axis_encoder.sv
`timescale 1ns/1ps
module sim_alt_axis_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic strobe = 1'b0;
  logic enc, flag, valid;

  int checks = 0;
  int failures = 0;

  // bench reference state
  logic [1:0] m_ph;
  logic       m_prev;
  logic       m_flag;

  always #5 clk = ~clk;

  alt_axis_encoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .strobe_i(strobe),
    .enc_o(enc), .flag_o(flag), .valid_o(valid)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic m_enc();
    return (m_ph == 2'd0) || (m_ph == 2'd1);
  endfunction

  // drive one strobed bit, advance model, check outputs after the edge
  task automatic send_bit(logic b, string req);
    @(negedge clk);
    bit_in = b;
    strobe = 1'b1;
    m_ph   = m_ph + ((b ^ m_prev) ? 2'd3 : 2'd1);
    m_prev = b;
    m_flag = ~m_flag;
    @(posedge clk);
    #1;
    check({req, " enc"}, enc, m_enc());
    check({req, " flag"}, flag, m_flag);
    check({req, " valid"}, valid, 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strobe = 1'b0;
      @(posedge clk);
      #1;
      check("R6 valid low", valid, 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    strobe = 1'b0;
    m_ph = 2'd0; m_prev = 1'b1; m_flag = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 enc", enc, 1);
    check("R1 flag", flag, 0);
    check("R1 valid", valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_all_ones();
    // R3: from reset all ones gives +Y,-X,-Y,+X -> enc 1,0,0,1
    logic exp_seq [4] = '{1'b1, 1'b0, 1'b0, 1'b1};
    t_reset();
    for (int i = 0; i < 4; i++) begin
      send_bit(1'b1, "R3 ones");
      check("R3 ones seq", enc, exp_seq[i]);
      idle(2);
    end
  endtask

  task automatic t_alternating();
    t_reset();
    for (int i = 0; i < 8; i++) begin
      send_bit(i[0], "R2 alternating");
      idle(1);
    end
  endtask

  task automatic t_hold();
    logic e0, f0;
    t_reset();
    send_bit(1'b0, "R5 setup");
    e0 = enc; f0 = flag;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      strobe = 1'b0;
      bit_in = ~bit_in;
      @(posedge clk);
      #1;
      check("R7 enc hold", enc, e0);
      check("R7 flag hold", flag, f0);
      check("R6 no valid", valid, 0);
    end
    // prev bit must be unaffected by the toggling above
    send_bit(1'b0, "R7 after hold");
  endtask

  task automatic t_back_to_back();
    logic [7:0] lfsr = 8'hA5;
    t_reset();
    for (int i = 0; i < 40; i++) begin
      send_bit(lfsr[0], "R8 back to back");
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    idle(1);
  endtask

  task automatic t_mixed();
    logic [15:0] pat = 16'b1100_1010_0111_0001;
    t_reset();
    for (int i = 0; i < 16; i++) begin
      send_bit(pat[i], "R4 R5 mixed");
      idle(i % 3);
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_all_ones();
    t_alternating();
    t_hold();
    t_back_to_back();
    t_mixed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule